// File: doc/BRIEF.md
# Daisy-Chain FIFO Stage Token Controller

This block sits beside the storage of one FIFO stage and decides when that stage may take part in a write or a read. Several such stages can be chained to build one deeper FIFO. In that case, ownership of the write side and of the read side passes from stage to stage as two tokens. A stage accepts a write only while it holds the write token, and it serves a read only while it holds the read token. When a stage writes its final location it hands the write token on with a one-cycle pulse to the next stage. Reads hand on the read token the same way. The last stage's pulses feed back to the first stage, so the chain forms a ring.

A static chain-mode input selects between chained operation and stand-alone operation. In stand-alone mode no tokens circulate, and the pin that carries the write hand-off pulse instead reports whether the stage is more than half full. A second static input, the follower flag, picks which stage starts with both tokens: it is low only on the first stage. The storage array is not part of the block. It is represented by a write address, a read address and a fill count. Both sides run on one clock.

Top module: `dx_stage_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising edge, both addresses go to 0, the fill count goes to 0 (`empty_o`=1, `full_o`=0), and `rpass_o` goes to 0. `wpass_hfn_o` goes to 0 in chain mode and to 1 in stand-alone mode. Both tokens go to 1, except in chain mode with `chain_follower_i`=1, where both go to 0.
- R2: A write is granted (`wr_fire_o`=1) when `wr_req_i` is high, the write token is held and the stage is not full. Each granted write advances `wr_addr_o` by one at the next edge, and address DEPTH-1 wraps to 0.
- R3: A read is granted (`rd_fire_o`=1) when `rd_req_i` is high, the read token is held and the stage is not empty. Each granted read advances `rd_addr_o` by one at the next edge, and address DEPTH-1 wraps to 0.
- R4: In chain mode, a granted write at address DEPTH-1 clears the write token at that edge. It also drives `wpass_hfn_o` high for exactly the following cycle.
- R5: In chain mode, a granted read at address DEPTH-1 clears the read token at that edge. It also drives `rpass_o` high for exactly the following cycle.
- R6: In chain mode, if `wtake_i` is high at rising edge k, `wtoken_o` is 1 after edge k+1. Unless the write token is given up at edge k+1, in which case giving up wins. A take pulse that arrives while the token is already held leaves it held.
- R7: In chain mode, `rtake_i` acts on the read token as R6 describes for the write token.
- R8: In stand-alone mode, both tokens stay at 1 and `rpass_o` stays 0. `wtake_i` and `rtake_i` have no effect. `wpass_hfn_o` is 0 exactly when the fill count exceeds DEPTH/2.
- R9: The fill count rises by one on each granted write and falls by one on each granted read. `full_o` is 1 at count DEPTH and `empty_o` is 1 at count 0. No write is granted when full and no read is granted when empty, and the count never leaves 0..DEPTH.
- R10: A request made without the matching token is not granted and leaves the addresses and the fill count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| chain_mode_i | input | 1 | 1 = chained (token) mode, 0 = stand-alone; held stable through reset |
| chain_follower_i | input | 1 | 0 on the first stage of the chain, 1 on all others |
| wr_req_i | input | 1 | Write request |
| rd_req_i | input | 1 | Read request |
| wtake_i | input | 1 | Write hand-off pulse from the previous stage |
| rtake_i | input | 1 | Read hand-off pulse from the previous stage |
| wr_fire_o | output | 1 | Write granted this cycle |
| wr_addr_o | output | AW | Storage write address |
| rd_fire_o | output | 1 | Read granted this cycle |
| rd_addr_o | output | AW | Storage read address |
| wtoken_o | output | 1 | Write token held |
| rtoken_o | output | 1 | Read token held |
| full_o | output | 1 | Fill count equals DEPTH |
| empty_o | output | 1 | Fill count is zero |
| wpass_hfn_o | output | 1 | Chain mode: write hand-off pulse; stand-alone: active-low half-full |
| rpass_o | output | 1 | Read hand-off pulse to the next stage |

## Verification
The bench writes the stage through its final location. This catches a design that never drops the write token, or that holds the hand-off pulse for more than one cycle: it would keep accepting writes or would hand over twice. It sends take pulses while the stage already holds the token, and again during the two-edge acquisition window. A design with the wrong take latency would grant a write one cycle early or late. In stand-alone mode it crosses the half-full point and sends take pulses that must change nothing, which catches a shared pin that shows the pulse in the wrong mode. It also issues requests against a full stage, an empty stage and a stage without a token, which catches a design that advances an address or the count without a grant.

// File: rtl/dx_pkg.sv
// Package: shared types for the daisy-chain stage controller.
// Assumes: nothing beyond IEEE 1800-2017.
package dx_pkg;

    // Operating mode of a stage, chosen statically at reset.
    typedef enum logic {
        MODE_SOLO  = 1'b0,
        MODE_CHAIN = 1'b1
    } chain_mode_e;

    // Reset value of a token for a given mode and chain position.
    function automatic logic token_at_reset(chain_mode_e mode, logic follower);
        return (mode == MODE_CHAIN) ? ~follower : 1'b1;
    endfunction

endpackage

// File: rtl/dx_token_side.sv
// Module: one side (write or read) of a chained FIFO stage.
// Grants requests while the side's token is held and the fill level allows it.
// Keeps the storage address, hands the token on with a one-cycle pulse after
// the final location is used, and takes the token back one edge after it
// samples an incoming hand-off pulse.
// Assumes: chain_i is stable while rst_n is high; DEPTH >= 2.
module dx_token_side
    import dx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chain_i,
    input  logic          follower_i,
    input  logic          req_i,
    input  logic          room_i,
    input  logic          take_i,
    output logic          fire_o,
    output logic [AW-1:0] addr_o,
    output logic          token_o,
    output logic          pass_o
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

    logic [AW-1:0] addr_q;
    logic          token_q;
    logic          take_q;
    logic          pass_q;
    logic          at_last;
    chain_mode_e   mode;

    assign mode    = chain_mode_e'(chain_i);
    assign at_last = (addr_q == LAST_ADDR);

    // Grant: a request counts only with the token and room to act.
    assign fire_o = req_i & token_q & room_i;

    // Register the incoming hand-off pulse; ignored outside chain mode.
    always_ff @(posedge clk) begin
        if (!rst_n) take_q <= 1'b0;
        else        take_q <= (mode == MODE_CHAIN) & take_i;
    end

    // Address counter that wraps after the final location.
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_q <= '0;
        else if (fire_o) addr_q <= at_last ? '0 : addr_q + AW'(1);
    end

    // Token ownership: giving it up wins over taking it in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                      token_q <= token_at_reset(mode, follower_i);
        else if (mode != MODE_CHAIN)     token_q <= 1'b1;
        else if (fire_o && at_last)      token_q <= 1'b0;
        else if (take_q)                 token_q <= 1'b1;
    end

    // Outgoing hand-off pulse, one cycle after the final location is used.
    always_ff @(posedge clk) begin
        if (!rst_n) pass_q <= 1'b0;
        else        pass_q <= (mode == MODE_CHAIN) & fire_o & at_last;
    end

    assign addr_o  = addr_q;
    assign token_o = token_q;
    assign pass_o  = pass_q;

    // Hand-off pulse lasts one cycle (R4 on the write side, R5 on the read side).
    assert_pass_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |=> !pass_o);

    // While the hand-off pulse is out, the token is no longer held (R4 / R5).
    assert_pass_drops_token_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> !token_o);

    // The address moves only after a request made with token and room (R2 / R3, R10).
    assert_addr_moves_on_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_o != $past(addr_o)) |-> $past(req_i && token_o && room_i));

    // Stand-alone mode always holds the token (R8).
    assert_solo_holds_token_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !chain_i |-> token_o);

endmodule

// File: rtl/dx_fill_level.sv
// Module: fill counter of one stage.
// Tracks how many locations hold data and derives the full, empty and
// active-low half-full indications from the count.
// Assumes: the grant inputs never ask to write when full or read when empty.
module dx_fill_level #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_fire_i,
    input  logic rd_fire_i,
    output logic full_o,
    output logic empty_o,
    output logic half_n_o
);

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    logic [CW-1:0] count_q;

    // Count up on writes, down on reads, hold when both or neither.
    always_ff @(posedge clk) begin
        if (!rst_n)                       count_q <= '0;
        else if (wr_fire_i && !rd_fire_i) count_q <= count_q + CW'(1);
        else if (rd_fire_i && !wr_fire_i) count_q <= count_q - CW'(1);
    end

    assign full_o   = (count_q == FULL_CNT);
    assign empty_o  = (count_q == '0);
    assign half_n_o = ~(count_q > HALF_CNT);

    // Count stays within the storage size (R9).
    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL_CNT);

    // Count moves by at most one per cycle (R9).
    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (count_q == $past(count_q)) ||
        (count_q == $past(count_q) + CW'(1)) ||
        (count_q == $past(count_q) - CW'(1)));

endmodule

// File: rtl/dx_stage_ctrl.sv
// Module: top of the daisy-chain FIFO stage controller.
// Combines a write-side and a read-side token keeper with the fill counter.
// Shares one output pin between the write hand-off pulse (chain mode) and
// the active-low half-full flag (stand-alone mode).
// Assumes: chain_mode_i and chain_follower_i are static and held through reset;
// one clock serves both sides.
module dx_stage_ctrl
    import dx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chain_mode_i,
    input  logic          chain_follower_i,
    input  logic          wr_req_i,
    input  logic          rd_req_i,
    input  logic          wtake_i,
    input  logic          rtake_i,
    output logic          wr_fire_o,
    output logic [AW-1:0] wr_addr_o,
    output logic          rd_fire_o,
    output logic [AW-1:0] rd_addr_o,
    output logic          wtoken_o,
    output logic          rtoken_o,
    output logic          full_o,
    output logic          empty_o,
    output logic          wpass_hfn_o,
    output logic          rpass_o
);

    logic wpass;
    logic half_n;
    logic full;
    logic empty;

    // Write side: room means the stage is not full.
    dx_token_side #(.DEPTH(DEPTH), .AW(AW)) wr_side_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chain_i    (chain_mode_i),
        .follower_i (chain_follower_i),
        .req_i      (wr_req_i),
        .room_i     (~full),
        .take_i     (wtake_i),
        .fire_o     (wr_fire_o),
        .addr_o     (wr_addr_o),
        .token_o    (wtoken_o),
        .pass_o     (wpass)
    );

    // Read side: room means the stage is not empty.
    dx_token_side #(.DEPTH(DEPTH), .AW(AW)) rd_side_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chain_i    (chain_mode_i),
        .follower_i (chain_follower_i),
        .req_i      (rd_req_i),
        .room_i     (~empty),
        .take_i     (rtake_i),
        .fire_o     (rd_fire_o),
        .addr_o     (rd_addr_o),
        .token_o    (rtoken_o),
        .pass_o     (rpass_o)
    );

    // Fill level shared by both sides.
    dx_fill_level #(.DEPTH(DEPTH)) fill_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_fire_i (wr_fire_o),
        .rd_fire_i (rd_fire_o),
        .full_o    (full),
        .empty_o   (empty),
        .half_n_o  (half_n)
    );

    // Shared pin: hand-off pulse when chained, half-full flag otherwise.
    assign wpass_hfn_o = (chain_mode_e'(chain_mode_i) == MODE_CHAIN) ? wpass : half_n;
    assign full_o      = full;
    assign empty_o     = empty;

    // No read hand-off outside chain mode (R8).
    assert_rpass_only_chained_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rpass_o |-> chain_mode_i);

    // No write granted into a full stage (R9).
    assert_no_write_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire_o |-> !full_o);

    // No read granted from an empty stage (R9).
    assert_no_read_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire_o |-> !empty_o);

endmodule

// File: tb/dx_stage_ctrl_tb.sv
`timescale 1ns/1ps
module dx_stage_ctrl_tb_top;

    localparam int D  = 16;
    localparam int AW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chain_mode = 1'b0;
    logic          follower = 1'b0;
    logic          wr_req = 1'b0;
    logic          rd_req = 1'b0;
    logic          wtake = 1'b0;
    logic          rtake = 1'b0;
    logic          wr_fire;
    logic [AW-1:0] wr_addr;
    logic          rd_fire;
    logic [AW-1:0] rd_addr;
    logic          wtoken;
    logic          rtoken;
    logic          full;
    logic          empty;
    logic          wpass_hfn;
    logic          rpass;

    always #2.5 clk = ~clk;

    dx_stage_ctrl #(.DEPTH(D)) dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .chain_mode_i     (chain_mode),
        .chain_follower_i (follower),
        .wr_req_i         (wr_req),
        .rd_req_i         (rd_req),
        .wtake_i          (wtake),
        .rtake_i          (rtake),
        .wr_fire_o        (wr_fire),
        .wr_addr_o        (wr_addr),
        .rd_fire_o        (rd_fire),
        .rd_addr_o        (rd_addr),
        .wtoken_o         (wtoken),
        .rtoken_o         (rtoken),
        .full_o           (full),
        .empty_o          (empty),
        .wpass_hfn_o      (wpass_hfn),
        .rpass_o          (rpass)
    );

    typedef struct {
        int wa;
        int ra;
        bit wt;
        bit rt;
        bit wp;
        bit rp;
        bit fl;
        bit em;
        bit solo;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // Reference state built from the requirements.
    bit m_mode, m_wt, m_rt, m_wtq, m_rtq;
    int m_wa, m_ra, m_cnt;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    // Reset into a mode and check the reset state (R1).
    task automatic do_reset(input bit mode, input bit fol);
        @(negedge clk);
        rst_n = 1'b0; chain_mode = mode; follower = fol;
        wr_req = 0; rd_req = 0; wtake = 0; rtake = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_mode = mode; m_wa = 0; m_ra = 0; m_cnt = 0; m_wtq = 0; m_rtq = 0;
        m_wt = mode ? !fol : 1'b1;
        m_rt = m_wt;
        #1;
        chk(wr_addr == 0, "R1", "wr_addr", wr_addr, 0);
        chk(rd_addr == 0, "R1", "rd_addr", rd_addr, 0);
        chk(wtoken == m_wt, "R1", "wtoken", wtoken, m_wt);
        chk(rtoken == m_rt, "R1", "rtoken", rtoken, m_rt);
        chk(empty == 1'b1 && full == 1'b0, "R1", "empty/full", {empty, full}, 2);
        chk(wpass_hfn == !mode, "R1", "wpass_hfn", wpass_hfn, !mode);
        chk(rpass == 1'b0, "R1", "rpass", rpass, 0);
    endtask

    // Driver: apply one cycle of stimulus, check grants, push expected state.
    task automatic step(input bit w, input bit r, input bit wt_in, input bit rt_in);
        exp_t  e;
        bit    wf, rf, lw, lr;
        string wtag, rtag;
        wr_req = w; rd_req = r; wtake = wt_in; rtake = rt_in;
        #1;
        wf = w && m_wt && (m_cnt < D);
        rf = r && m_rt && (m_cnt > 0);
        wtag = (w && !m_wt) ? "R10" : (w && m_cnt >= D) ? "R9" : "R2";
        rtag = (r && !m_rt) ? "R10" : (r && m_cnt == 0) ? "R9" : "R3";
        chk(wr_fire == wf, wtag, "wr_fire", wr_fire, wf);
        chk(rd_fire == rf, rtag, "rd_fire", rd_fire, rf);
        lw = wf && (m_wa == D - 1);
        lr = rf && (m_ra == D - 1);
        e.wa = wf ? (lw ? 0 : m_wa + 1) : m_wa;
        e.ra = rf ? (lr ? 0 : m_ra + 1) : m_ra;
        e.wt = !m_mode ? 1'b1 : lw ? 1'b0 : m_wtq ? 1'b1 : m_wt;
        e.rt = !m_mode ? 1'b1 : lr ? 1'b0 : m_rtq ? 1'b1 : m_rt;
        e.wp = m_mode && lw;
        e.rp = m_mode && lr;
        m_cnt = m_cnt + int'(wf) - int'(rf);
        e.fl = (m_cnt == D);
        e.em = (m_cnt == 0);
        e.solo = !m_mode;
        if (e.solo) e.wp = !(m_cnt > D / 2);
        m_wtq = m_mode && wt_in;
        m_rtq = m_mode && rt_in;
        m_wa = e.wa; m_ra = e.ra; m_wt = e.wt; m_rt = e.rt;
        exp_q.push_back(e);
        @(negedge clk);
        wr_req = 0; rd_req = 0; wtake = 0; rtake = 0;
    endtask

    // Monitor: after each edge, compare the registered outputs with the queue.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk(wr_addr == AW'(e.wa), "R2", "wr_addr", wr_addr, e.wa);
            chk(rd_addr == AW'(e.ra), "R3", "rd_addr", rd_addr, e.ra);
            chk(wtoken == e.wt, e.solo ? "R8" : "R6", "wtoken", wtoken, e.wt);
            chk(rtoken == e.rt, e.solo ? "R8" : "R7", "rtoken", rtoken, e.rt);
            chk(wpass_hfn == e.wp, e.solo ? "R8" : "R4", "wpass_hfn", wpass_hfn, e.wp);
            chk(rpass == e.rp, e.solo ? "R8" : "R5", "rpass", rpass, e.rp);
            chk(full == e.fl, "R9", "full", full, e.fl);
            chk(empty == e.em, "R9", "empty", empty, e.em);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // Stand-alone mode: half-full, full, empty and ignored take pulses (R8, R9).
        do_reset(1'b0, 1'b0);
        repeat (9) step(1, 0, 0, 0);
        step(0, 0, 1, 1);
        repeat (7) step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 1, 0, 0);
        repeat (16) step(0, 1, 0, 0);
        step(0, 1, 0, 0);
        step(1, 1, 0, 0);
        step(0, 1, 0, 0);

        // Chain mode, first stage: hand-offs and token return (R4, R5, R6, R7, R10).
        do_reset(1'b1, 1'b0);
        step(0, 0, 1, 1);
        step(0, 0, 0, 0);
        repeat (16) step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        repeat (16) step(0, 1, 0, 0);
        step(0, 1, 0, 0);
        step(1, 1, 1, 1);
        step(1, 1, 0, 0);
        step(1, 0, 0, 0);
        step(0, 1, 0, 0);
        step(0, 0, 0, 0);

        // Chain mode, follower stage: no tokens until handed in (R1, R6, R7, R10).
        do_reset(1'b1, 1'b1);
        step(1, 1, 0, 0);
        step(0, 0, 1, 0);
        step(1, 0, 0, 0);
        repeat (3) step(1, 0, 0, 0);
        step(0, 1, 0, 0);
        step(0, 0, 0, 1);
        step(0, 1, 0, 0);
        repeat (3) step(0, 1, 0, 0);
        step(0, 0, 0, 0);

        repeat (2) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule